// File: doc/BRIEF.md
# Four-Level Long-Mode Page Walker

This block translates a 64-bit virtual address into a physical page by reading up to four levels of 64-bit translation-table entries through a single request/acknowledge memory port. A walk is launched with a one-cycle start pulse together with the address, the root table pointer, an address-line mask and a no-execute enable. The block first rejects addresses that are not canonical. After that it fetches one entry per level and checks it for presence and reserved bits. A walk stops early when it reaches a 1 GB or 2 MB large page.

While it descends, the block folds the no-execute, user and writable bits of every level into one combined permission set. Any upper-level entry whose accessed flag is clear is written back with the flag set. At the end of the walk the block pulses `done_o` and presents the page base, the size code, the combined permissions, the last entry fetched with its address, and a two-bit fault code. Checking the access against these permissions, building the error code and caching the translation belong to the surrounding logic.

Entry bit positions used throughout: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, page-size = bit 7, no-execute = bit 63. Fault codes: 0 none, 1 not-present, 2 reserved-bit, 3 non-canonical. Size codes: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB.

Top module: `lm_page_walker`

## Requirements
- R1: If bits 63:47 of the virtual address are neither all zeros nor all ones, the walk ends with fault code 3 and makes no memory access. `done_o` is high in the cycle after the clock edge that accepted the start, and `leaf_o` and `leaf_addr_o` are zero. An address whose upper bits are all ones walks normally.
- R2: Level k (k = 0..3) takes its 9-bit index from virtual-address bits [47-9k : 39-9k]. The entry address is the current table base plus index × 8. The first table base is the root input with its low 12 bits ignored, and each later base is bits PA_W-1:12 of the previous entry.
- R3: Every entry address is ANDed with `a20_mask_i` before it is presented on `mem_addr_o`.
- R4: An entry whose present bit (bit 0) is clear ends the walk with fault code 1. `leaf_o` and `leaf_addr_o` then hold the failing entry and its address.
- R5: An entry with any bit in 51:PA_W set ends the walk with fault code 2. When `nx_en_i` is low, a set bit 63 also counts as reserved.
- R6: A set page-size bit (bit 7) in the level-0 entry ends the walk with fault code 2.
- R7: `perm_o` = {no-execute, user, writable}. No-execute is the OR of bit 63 over all fetched levels. User (bit 2) and writable (bit 1) are each the AND over all fetched levels.
- R8: A non-leaf entry with the accessed bit (bit 5) clear is written back to the same address with bit 5 set, before the next level is read. Leaf entries are never written.
- R9: A set page-size bit ends the walk at level 1 as a 1 GB page (size code 2) or at level 2 as a 2 MB page (size code 1). Otherwise the level-3 entry is a 4 KB leaf (size code 0). `page_base_o` is the leaf's bits PA_W-1:12, aligned down to the page size.
- R10: For a large page, a leaf with any set bit from bit 13 up to the page-size boundary (bit 29 for 1 GB, bit 20 for 2 MB) gives fault code 2. Bit 12 is exempt and is cleared from the page base.
- R11: `busy_o` is high from the accepting edge until the end of the `done_o` cycle, and a start during that time is ignored. At most one access is outstanding, and it is held stable until `mem_ack_i`. `done_o` lasts exactly one cycle.
- R12: After reset the block is idle, with `busy_o`, `done_o` and `mem_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a walk (accepted when idle) |
| va_i | input | 64 | Virtual address to translate |
| root_i | input | PA_W | Root table pointer, low 12 bits ignored |
| a20_mask_i | input | PA_W | Mask ANDed into every entry address |
| nx_en_i | input | 1 | No-execute support enabled |
| busy_o | output | 1 | Walk in progress or result being presented |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 2 | Fault code |
| page_size_o | output | 2 | Size code of the leaf |
| perm_o | output | 3 | Combined {no-execute, user, writable} |
| page_base_o | output | PA_W | Physical page base, size-aligned |
| leaf_o | output | 64 | Last entry fetched |
| leaf_addr_o | output | PA_W | Address of the last entry fetched |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | PA_W | Entry address |
| mem_wdata_o | output | 64 | Write-back data |
| mem_ack_i | input | 1 | Access completed; read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
A non-canonical address is the only case with a fixed latency. Its result is due in the cycle right after the accepting edge, and the bench samples `done_o` at the falling edge of that same cycle. Every other result arrives one cycle after the acknowledge of the last read, so its timing depends on the memory latency. The scoreboard therefore keys on the `done_o` strobe rather than a cycle count. With each result it compares the number of reads and write-backs the memory model served, which pins down how deep the walk went and which levels were written. A stray start during a walk, and any second strobe, would pop an empty queue and are reported.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int LEVELS   = 4;
  localparam int IDX_W    = 9;
  localparam int PG_SHIFT = 12;
  localparam int VA_TOP   = 47;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_PS   = 7;
  localparam int B_NX   = 63;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_ABSENT   = 2'd1,
    FLT_RSVD     = 2'd2,
    FLT_NONCANON = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_2M = 2'd1,
    SZ_1G = 2'd2
  } pgsz_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MARK,
    ST_DONE
  } st_e;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [PA_W-13:0] base_frame,
  input  logic [VA_TOP:0]  va,
  input  logic [1:0]       lvl,
  input  logic [PA_W-1:0]  a20_mask,
  output logic [PA_W-1:0]  ent_addr
);
  localparam int ZPAD = PA_W - PG_SHIFT;

  logic [IDX_W-1:0] idx_w [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_w[g] = va[VA_TOP - IDX_W*g -: IDX_W];
  end

  logic [PA_W-1:0] offs;
  assign offs     = {{ZPAD{1'b0}}, idx_w[lvl], 3'b000};
  assign ent_addr = ({base_frame, {PG_SHIFT{1'b0}}} | offs) & a20_mask;

  logic unused_va_low;
  assign unused_va_low = ^va[PG_SHIFT-1:0];
endmodule

// File: rtl/pgw_entry_chk.sv
module pgw_entry_chk
  import pgw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [63:0] ent,
  input  logic [1:0]  lvl,
  input  logic        nx_en,
  output flt_e        flt,
  output logic        is_leaf,
  output logic        need_mark,
  output pgsz_e       size
);
  logic [63:0] hi_mask;
  logic [63:0] lg_mask;
  logic        is_large;
  logic        rsvd;

  always_comb begin
    for (int i = 0; i < 64; i++) begin
      hi_mask[i] = (i >= PA_W) && (i <= 51);
      if (lvl == 2'd1) lg_mask[i] = (i >= 13) && (i <= 29);
      else             lg_mask[i] = (i >= 13) && (i <= 20);
    end
    is_large  = ((lvl == 2'd1) || (lvl == 2'd2)) && ent[B_PS];
    is_leaf   = (lvl == 2'd3) || is_large;
    rsvd      = (|(ent & hi_mask)) ||
                (!nx_en && ent[B_NX]) ||
                ((lvl == 2'd0) && ent[B_PS]) ||
                (is_large && (|(ent & lg_mask)));
    if (!ent[B_PRES]) flt = FLT_ABSENT;
    else if (rsvd)    flt = FLT_RSVD;
    else              flt = FLT_NONE;
    need_mark = !is_leaf && !ent[B_ACC];
    if (!is_large)         size = SZ_4K;
    else if (lvl == 2'd1)  size = SZ_1G;
    else                   size = SZ_2M;
  end
endmodule

// File: rtl/pgw_perm_acc.sv
module pgw_perm_acc
  import pgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [2:0] ent_bits,
  output logic [2:0] perm
);
  // Held in inverted-no-execute form: bit 2 is "executable".
  logic [2:0] acc_q, acc_d;
  logic       acc_ce;

  assign acc_ce = clr || en;

  always_comb begin
    if (clr) acc_d = 3'b111;
    else     acc_d = acc_q & {~ent_bits[2], ent_bits[1], ent_bits[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= 3'b111;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign perm = {~acc_q[2], acc_q[1], acc_q[0]};
endmodule

// File: rtl/lm_page_walker.sv
module lm_page_walker
  import pgw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [63:0]     va_i,
  input  logic [PA_W-1:0] root_i,
  input  logic [PA_W-1:0] a20_mask_i,
  input  logic            nx_en_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [1:0]      fault_o,
  output logic [1:0]      page_size_o,
  output logic [2:0]      perm_o,
  output logic [PA_W-1:0] page_base_o,
  output logic [63:0]     leaf_o,
  output logic [PA_W-1:0] leaf_addr_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [PA_W-1:0] mem_addr_o,
  output logic [63:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [63:0]     mem_rdata_i
);
  localparam int FR_W = PA_W - PG_SHIFT;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  st_e              st_q, st_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [VA_TOP:0]  va_q, va_d;
  logic [FR_W-1:0]  frame_q, frame_d;
  logic [PA_W-1:0]  a20_q, a20_d;
  logic             nxen_q, nxen_d;
  logic [63:0]      ent_q, ent_d;
  flt_e             flt_q, flt_d;
  pgsz_e            sz_q, sz_d;
  logic [63:0]      leaf_q, leaf_d;
  logic [PA_W-1:0]  laddr_q, laddr_d;
  logic [PA_W-1:0]  base_q, base_d;

  logic             walk_ce, res_ce, acc_clr, acc_en;

  logic [PA_W-1:0]  ent_addr;
  flt_e             chk_flt;
  logic             chk_leaf, chk_mark;
  pgsz_e            chk_sz;
  logic             canon;
  logic [PA_W-1:0]  keep;

  pgw_addr_gen #(.PA_W(PA_W)) u_addr (
    .base_frame (frame_q),
    .va         (va_q),
    .lvl        (lvl_q),
    .a20_mask   (a20_q),
    .ent_addr   (ent_addr)
  );

  pgw_entry_chk #(.PA_W(PA_W)) u_chk (
    .ent       (mem_rdata_i),
    .lvl       (lvl_q),
    .nx_en     (nxen_q),
    .flt       (chk_flt),
    .is_leaf   (chk_leaf),
    .need_mark (chk_mark),
    .size      (chk_sz)
  );

  pgw_perm_acc u_perm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr      (acc_clr),
    .en       (acc_en),
    .ent_bits ({mem_rdata_i[B_NX], mem_rdata_i[B_USR], mem_rdata_i[B_WR]}),
    .perm     (perm_o)
  );

  assign canon = (&va_i[63:VA_TOP]) || !(|va_i[63:VA_TOP]);

  always_comb begin
    keep = '1;
    keep[PG_SHIFT-1:0] = '0;
    if (chk_sz == SZ_2M) keep[20:0] = '0;
    if (chk_sz == SZ_1G) keep[29:0] = '0;
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    va_d    = va_q;
    frame_d = frame_q;
    a20_d   = a20_q;
    nxen_d  = nxen_q;
    ent_d   = ent_q;
    flt_d   = flt_q;
    sz_d    = sz_q;
    leaf_d  = leaf_q;
    laddr_d = laddr_q;
    base_d  = base_q;
    walk_ce = 1'b0;
    res_ce  = 1'b0;
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          walk_ce = 1'b1;
          res_ce  = 1'b1;
          acc_clr = 1'b1;
          va_d    = va_i[VA_TOP:0];
          frame_d = root_i[PA_W-1:PG_SHIFT];
          a20_d   = a20_mask_i;
          nxen_d  = nx_en_i;
          lvl_d   = 2'd0;
          sz_d    = SZ_4K;
          leaf_d  = '0;
          laddr_d = '0;
          base_d  = '0;
          if (canon) begin
            flt_d = FLT_NONE;
            st_d  = ST_FETCH;
          end else begin
            flt_d = FLT_NONCANON;
            st_d  = ST_DONE;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          acc_en = 1'b1;
          if ((chk_flt != FLT_NONE) || chk_leaf) begin
            res_ce  = 1'b1;
            flt_d   = chk_flt;
            sz_d    = chk_sz;
            leaf_d  = mem_rdata_i;
            laddr_d = ent_addr;
            base_d  = {mem_rdata_i[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} & keep;
            st_d    = ST_DONE;
          end else if (chk_mark) begin
            walk_ce = 1'b1;
            ent_d   = mem_rdata_i | (64'd1 << B_ACC);
            st_d    = ST_MARK;
          end else begin
            walk_ce = 1'b1;
            frame_d = mem_rdata_i[PA_W-1:PG_SHIFT];
            lvl_d   = lvl_q + 2'd1;
          end
        end
      end
      ST_MARK: begin
        if (mem_ack_i) begin
          walk_ce = 1'b1;
          frame_d = ent_q[PA_W-1:PG_SHIFT];
          lvl_d   = lvl_q + 2'd1;
          st_d    = ST_FETCH;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lvl_q   <= 2'd0;
      va_q    <= '0;
      frame_q <= '0;
      a20_q   <= '0;
      nxen_q  <= 1'b0;
      ent_q   <= '0;
      flt_q   <= FLT_NONE;
      sz_q    <= SZ_4K;
      leaf_q  <= '0;
      laddr_q <= '0;
      base_q  <= '0;
    end else begin
      st_q <= st_d;
      if (walk_ce) begin
        lvl_q   <= lvl_d;
        va_q    <= va_d;
        frame_q <= frame_d;
        a20_q   <= a20_d;
        nxen_q  <= nxen_d;
        ent_q   <= ent_d;
      end
      if (res_ce) begin
        flt_q   <= flt_d;
        sz_q    <= sz_d;
        leaf_q  <= leaf_d;
        laddr_q <= laddr_d;
        base_q  <= base_d;
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign mem_req_o   = (st_q == ST_FETCH) || (st_q == ST_MARK);
  assign mem_we_o    = (st_q == ST_MARK);
  assign mem_addr_o  = ent_addr;
  assign mem_wdata_o = ent_q;
  assign fault_o     = flt_q;
  assign page_size_o = sz_q;
  assign page_base_o = base_q;
  assign leaf_o      = leaf_q;
  assign leaf_addr_o = laddr_q;

  logic unused_root_low;
  assign unused_root_low = ^root_i[PG_SHIFT-1:0];
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy_o,
  input logic            done_o,
  input logic [1:0]      fault_o,
  input logic [1:0]      page_size_o,
  input logic [PA_W-1:0] a20_mask_i,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic [63:0]     mem_wdata_o,
  input logic            mem_ack_i
);
  a_r11_write_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_request_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  a_r3_address_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ((mem_addr_o & ~a20_mask_i) == '0));

  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

  a_r8_writeback_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[5]);

  a_r9_size_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (fault_o == 2'd0)) |-> (page_size_o != 2'd3));

  a_r1_noncanon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (fault_o == 2'd3)) |-> !$past(mem_req_o));
endmodule

bind lm_page_walker pgw_checker #(.PA_W(PA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .page_size_o (page_size_o),
  .a20_mask_i  (a20_mask_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/lm_page_walker_tb_top.sv
module lm_page_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 40;
  localparam int LAT  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [63:0]     va_i = '0;
  logic [PA_W-1:0] root_i = '0;
  logic [PA_W-1:0] a20_mask_i = '1;
  logic            nx_en_i = 1'b1;
  logic            busy_o, done_o;
  logic [1:0]      fault_o, page_size_o;
  logic [2:0]      perm_o;
  logic [PA_W-1:0] page_base_o, leaf_addr_o, mem_addr_o;
  logic [63:0]     leaf_o, mem_wdata_o;
  logic            mem_req_o, mem_we_o;
  logic            mem_ack_i = 1'b0;
  logic [63:0]     mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lm_page_walker #(.PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .root_i(root_i),
    .a20_mask_i(a20_mask_i), .nx_en_i(nx_en_i), .busy_o(busy_o), .done_o(done_o),
    .fault_o(fault_o), .page_size_o(page_size_o), .perm_o(perm_o),
    .page_base_o(page_base_o), .leaf_o(leaf_o), .leaf_addr_o(leaf_addr_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  typedef struct {
    string           tag;
    logic [1:0]      flt;
    logic [1:0]      sz;
    logic [2:0]      perm;
    logic [63:0]     leaf;
    logic [PA_W-1:0] laddr;
    logic [PA_W-1:0] base;
    int              reads;
    int              writes;
  } exp_t;

  exp_t        sbq[$];
  logic [63:0] pmem [longint];
  int total = 0, bad = 0, n_done = 0, rd_cnt = 0, wr_cnt = 0, lat_cnt = 0;

  localparam logic [63:0] F = 64'h27;   // present|writable|user|accessed
  localparam logic [63:0] LEAF4K = 64'h12_3456_7027;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t mk(input string tag, input logic [1:0] flt, input logic [1:0] sz,
                              input logic [2:0] perm, input logic [63:0] leaf,
                              input logic [PA_W-1:0] laddr, input logic [PA_W-1:0] base,
                              input int r, input int w);
    exp_t e;
    e.tag = tag; e.flt = flt; e.sz = sz; e.perm = perm; e.leaf = leaf;
    e.laddr = laddr; e.base = base; e.reads = r; e.writes = w;
    return e;
  endfunction

  function automatic logic [63:0] mkva(input logic [15:0] hi, input logic [8:0] a,
                                       input logic [8:0] b, input logic [8:0] c,
                                       input logic [8:0] d);
    return {hi, a, b, c, d, 12'habc};
  endfunction

  task automatic tables(input logic [63:0] e0, input logic [63:0] e1,
                        input logic [63:0] e2, input logic [63:0] e3);
    pmem.delete();
    pmem[64'h1008] = e0;
    pmem[64'h2010] = e1;
    pmem[64'h3018] = e2;
    pmem[64'h4020] = e3;
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (done_o) begin
      if (sbq.size() == 0) begin
        chk("R11 unexpected done strobe", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk({e.tag, " fault"}, 64'(fault_o), 64'(e.flt));
        chk({e.tag, " leaf entry"}, leaf_o, e.leaf);
        chk({e.tag, " leaf address"}, 64'(leaf_addr_o), 64'(e.laddr));
        chk({e.tag, " reads"}, 64'(rd_cnt), 64'(e.reads));
        chk({e.tag, " writebacks"}, 64'(wr_cnt), 64'(e.writes));
        if (e.flt == 2'd0) begin
          chk({e.tag, " size"}, 64'(page_size_o), 64'(e.sz));
          chk({e.tag, " perm"}, 64'(perm_o), 64'(e.perm));
          chk({e.tag, " base"}, 64'(page_base_o), 64'(e.base));
        end
      end
      n_done++;
      rd_cnt = 0;
      wr_cnt = 0;
    end
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      lat_cnt++;
      if (lat_cnt == LAT) begin
        longint key;
        key = longint'(mem_addr_o);
        lat_cnt = 0;
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          pmem[key] = mem_wdata_o;
          wr_cnt++;
        end else begin
          mem_rdata_i = pmem.exists(key) ? pmem[key] : 64'd0;
          rd_cnt++;
        end
      end
    end
  end

  task automatic launch(input logic [63:0] va);
    @(negedge clk);
    va_i = va;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int tgt);
    while (n_done < tgt) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic walk(input exp_t e, input logic [63:0] va);
    int tgt;
    tgt = n_done + 1;
    sbq.push_back(e);
    launch(va);
    wait_done(tgt);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] va1;
    va1 = mkva(16'h0, 9'd1, 9'd2, 9'd3, 9'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 busy after reset", 64'(busy_o), 64'd0);
    chk("R12 done after reset", 64'(done_o), 64'd0);
    chk("R12 request after reset", 64'(mem_req_o), 64'd0);

    // R2 plain 4 KB walk, root low bits ignored
    root_i = 40'h1abc;
    tables(64'h2000 | F, 64'h3000 | F, 64'h4000 | F, LEAF4K);
    walk(mk("R2", 2'd0, 2'd0, 3'b011, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0), va1);

    // R8 accessed write-back on upper levels
    tables(64'h2007, 64'h3007, 64'h4007, LEAF4K);
    walk(mk("R8", 2'd0, 2'd0, 3'b011, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 3), va1);
    chk("R8 level0 written", pmem[64'h1008], 64'h2027);
    chk("R8 level1 written", pmem[64'h2010], 64'h3027);
    chk("R8 level2 written", pmem[64'h3018], 64'h4027);
    chk("R8 leaf untouched", pmem[64'h4020], LEAF4K);

    // R9 2 MB page
    tables(64'h2000 | F, 64'h3000 | F, 64'h12_3440_00a7, 64'h0);
    walk(mk("R9 2M", 2'd0, 2'd1, 3'b011, 64'h12_3440_00a7, 40'h3018, 40'h12_3440_0000, 3, 0), va1);
    // R10 bit 12 exempt
    tables(64'h2000 | F, 64'h3000 | F, 64'h12_3440_10a7, 64'h0);
    walk(mk("R10 pat bit", 2'd0, 2'd1, 3'b011, 64'h12_3440_10a7, 40'h3018, 40'h12_3440_0000, 3, 0), va1);
    // R10 misaligned 2 MB leaf
    tables(64'h2000 | F, 64'h3000 | F, 64'h12_3440_20a7, 64'h0);
    walk(mk("R10 misaligned", 2'd2, 2'd0, 3'b000, 64'h12_3440_20a7, 40'h3018, 40'h0, 3, 0), va1);
    // R9 1 GB page
    tables(64'h2000 | F, 64'h12_4000_00a7, 64'h0, 64'h0);
    walk(mk("R9 1G", 2'd0, 2'd2, 3'b011, 64'h12_4000_00a7, 40'h2010, 40'h12_4000_0000, 2, 0), va1);

    // R4 not present at level 2
    tables(64'h2000 | F, 64'h3000 | F, 64'h4026, 64'h0);
    walk(mk("R4", 2'd1, 2'd0, 3'b000, 64'h4026, 40'h3018, 40'h0, 3, 0), va1);
    // R5 high reserved bit at level 1
    tables(64'h2000 | F, 64'h2000_0000_3027, 64'h0, 64'h0);
    walk(mk("R5 high bit", 2'd2, 2'd0, 3'b000, 64'h2000_0000_3027, 40'h2010, 40'h0, 2, 0), va1);
    // R6 page-size at top level
    tables(64'h20a7, 64'h0, 64'h0, 64'h0);
    walk(mk("R6", 2'd2, 2'd0, 3'b000, 64'h20a7, 40'h1008, 40'h0, 1, 0), va1);
    // R5 NX reserved when disabled
    nx_en_i = 1'b0;
    tables(64'h2000 | F, 64'h3000 | F, 64'h4000 | F, 64'h8000_0012_3456_7027);
    walk(mk("R5 nx disabled", 2'd2, 2'd0, 3'b000, 64'h8000_0012_3456_7027, 40'h4020, 40'h0, 4, 0), va1);
    nx_en_i = 1'b1;
    // R7 NX accumulates when enabled
    walk(mk("R7 nx leaf", 2'd0, 2'd0, 3'b111, 64'h8000_0012_3456_7027, 40'h4020, 40'h12_3456_7000, 4, 0), va1);
    // R7 user and writable fold as AND
    tables(64'h2000 | F, 64'h3025, 64'h4023, LEAF4K);
    walk(mk("R7 and-fold", 2'd0, 2'd0, 3'b000, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0), va1);
    tables(64'h8000_0000_0000_2027, 64'h3000 | F, 64'h4000 | F, LEAF4K);
    walk(mk("R7 upper nx", 2'd0, 2'd0, 3'b111, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0), va1);

    // R1 non-canonical: result due the cycle after the accepting edge
    begin
      int tgt;
      tgt = n_done + 1;
      sbq.push_back(mk("R1 noncanon", 2'd3, 2'd0, 3'b000, 64'h0, 40'h0, 40'h0, 0, 0));
      launch(64'h0000_8000_0000_0000);
      chk("R1 done timing", 64'(done_o), 64'd1);
      wait_done(tgt);
    end
    // R1 upper-half canonical address walks
    tables(64'h2000 | F, 64'h3000 | F, 64'h4000 | F, LEAF4K);
    pmem[64'h1ff8] = 64'h2000 | F;
    walk(mk("R1 upper half", 2'd0, 2'd0, 3'b011, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0),
         mkva(16'hffff, 9'h1ff, 9'd2, 9'd3, 9'd4));

    // R3 address mask clears bit 20 of the root
    tables(64'h2000 | F, 64'h3000 | F, 64'h4000 | F, LEAF4K);
    root_i = 40'h10_1abc;
    a20_mask_i = ~(40'h1 << 20);
    walk(mk("R3", 2'd0, 2'd0, 3'b011, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0), va1);
    a20_mask_i = '1;
    root_i = 40'h1000;

    // R11 start while busy is ignored
    begin
      int tgt;
      tgt = n_done + 1;
      sbq.push_back(mk("R11 busy start", 2'd0, 2'd0, 3'b011, LEAF4K, 40'h4020, 40'h12_3456_7000, 4, 0));
      launch(va1);
      repeat (3) @(negedge clk);
      chk("R11 busy during walk", 64'(busy_o), 64'd1);
      launch(64'h0000_8000_0000_0000);
      wait_done(tgt);
      repeat (10) @(negedge clk);
      chk("R11 single result", 64'(n_done), 64'(tgt));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule